// File: doc/BRIEF.md
# Reservation Station Pool with Shared Result Bus

This block is the scheduling core of an out-of-order back end. Renamed instructions arrive one per cycle and each is placed in a station that belongs to its class of function unit. A station holds the operation, the physical destination tag and two source tags. Each source tag has a flag that marks it as available. The pool watches a single result bus and sets the flag of every source whose tag appears there. Each cycle it sends at most one instruction whose operands are all available to a fully pipelined unit.

The units are modelled only by their fixed latency. Integer operations take one cycle. Load/store and floating-point operations take three. All units return results on the same bus, so the pool keeps a short record of which future bus cycles are already taken. It holds back any candidate whose result would land on a cycle that is already claimed. The bus output of the pool is the wakeup source for its own stations and for the rest of the machine.

There are five stations. Station 0 serves the integer unit, stations 1 and 2 serve load/store, and stations 3 and 4 serve floating point. Operand values, memory ordering and exceptions are handled elsewhere.

Top module: `rs_pool`

## Requirements
- R1: The unit code on dispatch selects the class: 0 integer, 1 load/store, 2 floating point. A dispatch goes to the lowest-numbered free station of its class. When no station of that class is free, `disp_stall` is high in that cycle and the instruction is not stored.
- R2: After reset no station is occupied. `disp_stall`, `iss_valid` and `cdb_valid` are all low while the bus is idle.
- R3: A station can issue only if it is occupied and both of its source flags are set.
- R4: When the bus carries a tag, every held source with that tag becomes available from the next cycle on. A source dispatched in the same cycle that its tag is on the bus is stored as available.
- R5: When several stations can issue, the one that was dispatched earliest issues.
- R6: At most one instruction issues per cycle. The issuing station is free from the following cycle. A dispatch to it during its issue cycle is stalled, and the same dispatch one cycle later is accepted.
- R7: An instruction that issues in cycle t puts its destination tag on the bus in cycle t+1 if it is an integer operation, and in cycle t+3 if it is a load/store or floating-point operation.
- R8: A station is held back while the bus cycle in which its result would appear is already claimed by an earlier issue. It issues once that cycle is free.
- R9: Three-cycle units accept a new instruction in each cycle, so independent long operations issue in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_unit | input | 2 | Unit class of the offered instruction |
| disp_op | input | OP_W | Operation code, carried to issue |
| disp_dst | input | TAG_W | Destination tag |
| disp_src1 | input | TAG_W | First source tag |
| disp_rdy1 | input | 1 | First source already available |
| disp_src2 | input | TAG_W | Second source tag |
| disp_rdy2 | input | 1 | Second source already available |
| disp_stall | output | 1 | Offered instruction is refused this cycle |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_unit | output | 2 | Unit class of the issuing instruction |
| iss_slot | output | IDX_W | Number of the issuing station |
| iss_op | output | OP_W | Operation code of the issuing instruction |
| iss_dst | output | TAG_W | Destination tag of the issuing instruction |
| cdb_valid | output | 1 | The result bus carries a tag this cycle |
| cdb_tag | output | TAG_W | Tag on the result bus |

## Verification
Some rules are checked by the assertions on every cycle. Grants are one-hot, and an issuing station is occupied and has both sources available. A station is vacant one cycle after it issues. Each issue reaches the bus after exactly its unit's latency. An integer issue never follows a long issue by two cycles. The bench scenarios are needed for the behaviour that depends on history. They show that the oldest candidate wins over younger ones and that a dispatch meeting its own tag on the bus is woken. They also show the stall and later acceptance around a full class, and the exact cycles in which an integer operation waits behind claimed bus slots.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    UC_ALU = 2'd0,
    UC_LS  = 2'd1,
    UC_FP  = 2'd2
  } unit_e;
endpackage

// File: rtl/rs_station.sv
// One reservation entry: payload, source flags and wakeup compare.
module rs_station #(
  parameter int OP_W  = 4,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  input  logic [OP_W-1:0]  fill_op,
  input  logic [TAG_W-1:0] fill_dst,
  input  logic [TAG_W-1:0] fill_src1,
  input  logic             fill_rdy1,
  input  logic [TAG_W-1:0] fill_src2,
  input  logic             fill_rdy2,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  input  logic             issue,
  output logic             busy,
  output logic             ready,
  output logic [OP_W-1:0]  op,
  output logic [TAG_W-1:0] dst
);
  logic             busy_q, busy_d;
  logic             rdy1_q, rdy1_d, rdy2_q, rdy2_d;
  logic [TAG_W-1:0] src1_q, src2_q;
  logic [OP_W-1:0]  op_q;
  logic [TAG_W-1:0] dst_q;

  always_comb begin
    busy_d = busy_q;
    rdy1_d = rdy1_q | (cdb_valid && cdb_tag == src1_q);
    rdy2_d = rdy2_q | (cdb_valid && cdb_tag == src2_q);
    if (fill) begin
      busy_d = 1'b1;
      rdy1_d = fill_rdy1 | (cdb_valid && cdb_tag == fill_src1);
      rdy2_d = fill_rdy2 | (cdb_valid && cdb_tag == fill_src2);
    end else if (issue) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk) begin
    rdy1_q <= rdy1_d;
    rdy2_q <= rdy2_d;
    if (fill) begin
      op_q   <= fill_op;
      dst_q  <= fill_dst;
      src1_q <= fill_src1;
      src2_q <= fill_src2;
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q & rdy1_q & rdy2_q;
  assign op    = op_q;
  assign dst   = dst_q;
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix: older_q[j][i] set means entry j was filled before entry i.
module rs_age_pick #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) older_d[i] = older_q[i];
    for (int i = 0; i < N; i++) begin
      if (alloc[i]) begin
        older_d[i] = '0;
        for (int j = 0; j < N; j++)
          if (j != i) older_d[j][i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) older_q[i] <= older_d[i];
    end
  end

  always_comb begin
    grant = '0;
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && req[j] && older_q[j][i]) beaten = 1'b1;
      grant[i] = req[i] & ~beaten;
    end
  end
endmodule

// File: rtl/rs_result_line.sv
// Latency delay line; entry k holds the tag due on the bus k cycles from now.
module rs_result_line #(
  parameter int TAG_W = 5,
  parameter int DEPTH = 3,
  parameter int LAT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LAT_W-1:0] push_lat,
  input  logic [TAG_W-1:0] push_tag,
  output logic [DEPTH:0]   occ,
  output logic             cdb_valid,
  output logic [TAG_W-1:0] cdb_tag
);
  logic [DEPTH-1:0] v_q, v_d;
  logic [TAG_W-1:0] t_q [DEPTH];
  logic [TAG_W-1:0] t_d [DEPTH];

  always_comb begin
    for (int k = 0; k < DEPTH - 1; k++) begin
      v_d[k] = v_q[k+1];
      t_d[k] = t_q[k+1];
    end
    v_d[DEPTH-1] = 1'b0;
    t_d[DEPTH-1] = t_q[DEPTH-1];
    if (push) begin
      v_d[push_lat - 1'b1] = 1'b1;
      t_d[push_lat - 1'b1] = push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) t_q[k] <= t_d[k];
  end

  assign occ       = {1'b0, v_q};
  assign cdb_valid = v_q[0];
  assign cdb_tag   = t_q[0];
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int OP_W     = 4,
  parameter int TAG_W    = 5,
  parameter int N_ALU    = 1,
  parameter int N_LS     = 2,
  parameter int N_FP     = 2,
  parameter int LAT_INT  = 1,
  parameter int LAT_LONG = 3,
  localparam int N       = N_ALU + N_LS + N_FP,
  localparam int IDX_W   = $clog2(N),
  localparam int LAT_W   = $clog2(LAT_LONG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [1:0]       disp_unit,
  input  logic [OP_W-1:0]  disp_op,
  input  logic [TAG_W-1:0] disp_dst,
  input  logic [TAG_W-1:0] disp_src1,
  input  logic             disp_rdy1,
  input  logic [TAG_W-1:0] disp_src2,
  input  logic             disp_rdy2,
  output logic             disp_stall,
  output logic             iss_valid,
  output logic [1:0]       iss_unit,
  output logic [IDX_W-1:0] iss_slot,
  output logic [OP_W-1:0]  iss_op,
  output logic [TAG_W-1:0] iss_dst,
  output logic             cdb_valid,
  output logic [TAG_W-1:0] cdb_tag
);
  import rs_pkg::*;

  function automatic unit_e unit_of(int idx);
    if (idx < N_ALU)        return UC_ALU;
    if (idx < N_ALU + N_LS) return UC_LS;
    return UC_FP;
  endfunction

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [N-1:0]     st_busy, st_ready, free_hit, fill, req, grant;
  logic [OP_W-1:0]  st_op  [N];
  logic [TAG_W-1:0] st_dst [N];
  logic [1:0]       st_unit[N];
  logic [LAT_LONG:0] occ;
  logic             found;
  logic [LAT_W-1:0] push_lat;

  for (genvar i = 0; i < N; i++) begin : g_st
    localparam unit_e UNIT = unit_of(i);
    localparam int    LAT  = (UNIT == UC_ALU) ? LAT_INT : LAT_LONG;

    assign st_unit[i]  = UNIT;
    assign free_hit[i] = (disp_unit == UNIT) && !st_busy[i];
    assign req[i]      = st_ready[i] && !occ[LAT];

    rs_station #(.OP_W(OP_W), .TAG_W(TAG_W)) u_st (
      .clk       (clk),
      .rst_n     (rst_q),
      .fill      (fill[i]),
      .fill_op   (disp_op),
      .fill_dst  (disp_dst),
      .fill_src1 (disp_src1),
      .fill_rdy1 (disp_rdy1),
      .fill_src2 (disp_src2),
      .fill_rdy2 (disp_rdy2),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .issue     (grant[i]),
      .busy      (st_busy[i]),
      .ready     (st_ready[i]),
      .op        (st_op[i]),
      .dst       (st_dst[i])
    );
  end

  // dispatch: lowest free station of the requested class
  always_comb begin
    found = 1'b0;
    fill  = '0;
    for (int i = 0; i < N; i++) begin
      if (free_hit[i] && !found) begin
        fill[i] = disp_valid;
        found   = 1'b1;
      end
    end
  end
  assign disp_stall = disp_valid && !found;

  rs_age_pick #(.N(N)) u_pick (
    .clk   (clk),
    .rst_n (rst_q),
    .alloc (fill),
    .req   (req),
    .grant (grant)
  );

  always_comb begin
    iss_slot = '0;
    iss_op   = '0;
    iss_dst  = '0;
    iss_unit = UC_ALU;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        iss_slot = IDX_W'(i);
        iss_op   = st_op[i];
        iss_dst  = st_dst[i];
        iss_unit = st_unit[i];
      end
    end
  end
  assign iss_valid = |grant;
  assign push_lat  = (iss_unit == UC_ALU) ? LAT_W'(LAT_INT) : LAT_W'(LAT_LONG);

  rs_result_line #(.TAG_W(TAG_W), .DEPTH(LAT_LONG), .LAT_W(LAT_W)) u_line (
    .clk       (clk),
    .rst_n     (rst_q),
    .push      (iss_valid),
    .push_lat  (push_lat),
    .push_tag  (iss_dst),
    .occ       (occ),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag)
  );
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int N        = 5,
  parameter int IDX_W    = 3,
  parameter int TAG_W    = 5,
  parameter int LAT_INT  = 1,
  parameter int LAT_LONG = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [1:0]       iss_unit,
  input logic [IDX_W-1:0] iss_slot,
  input logic [TAG_W-1:0] iss_dst,
  input logic             cdb_valid,
  input logic [TAG_W-1:0] cdb_tag,
  input logic [N-1:0]     st_busy,
  input logic [N-1:0]     st_ready,
  input logic [N-1:0]     grant
);
  p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_issue_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (st_busy[iss_slot] && st_ready[iss_slot]));

  p_free_after_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> !st_busy[$past(iss_slot)]);

  if (LAT_INT == 1 && LAT_LONG == 3) begin : g_lat
    p_int_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_unit == 2'd0) |=> (cdb_valid && cdb_tag == $past(iss_dst)));

    p_long_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_unit != 2'd0) |=> ##2 (cdb_valid && cdb_tag == $past(iss_dst, 3)));

    p_bus_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_unit == 2'd0) |-> !($past(iss_valid, 2) && $past(iss_unit, 2) != 2'd0));
  end
endmodule

bind rs_pool rs_pool_chk #(
  .N(N), .IDX_W(IDX_W), .TAG_W(TAG_W), .LAT_INT(LAT_INT), .LAT_LONG(LAT_LONG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .iss_valid (iss_valid),
  .iss_unit  (iss_unit),
  .iss_slot  (iss_slot),
  .iss_dst   (iss_dst),
  .cdb_valid (cdb_valid),
  .cdb_tag   (cdb_tag),
  .st_busy   (st_busy),
  .st_ready  (st_ready),
  .grant     (grant)
);

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0;
  logic [1:0] disp_unit = 2'd0;
  logic [3:0] disp_op = 4'd0;
  logic [4:0] disp_dst = 5'd0, disp_src1 = 5'd0, disp_src2 = 5'd0;
  logic       disp_rdy1 = 1'b0, disp_rdy2 = 1'b0;
  logic       disp_stall, iss_valid, cdb_valid;
  logic [1:0] iss_unit;
  logic [2:0] iss_slot;
  logic [3:0] iss_op;
  logic [4:0] iss_dst, cdb_tag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rs_pool dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_unit(disp_unit), .disp_op(disp_op),
    .disp_dst(disp_dst), .disp_src1(disp_src1), .disp_rdy1(disp_rdy1),
    .disp_src2(disp_src2), .disp_rdy2(disp_rdy2), .disp_stall(disp_stall),
    .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_slot(iss_slot),
    .iss_op(iss_op), .iss_dst(iss_dst),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag)
  );

  typedef struct packed {
    logic       dv;
    logic [1:0] u;
    logic [4:0] d;
    logic [4:0] s1;
    logic       r1;
    logic [4:0] s2;
    logic       r2;
    logic       xs;
    logic       xi;
    logic [4:0] xd;
    logic       xc;
    logic [4:0] xt;
    logic [3:0] rq;
  } vec_t;

  // load, multiply on its result, second load, add on both, integer op
  localparam vec_t TBL [13] = '{
    '{1, 1,  9,  5, 1,  0, 1,  0, 0,  0, 0,  0, 1},
    '{1, 2, 10,  9, 0,  4, 1,  0, 1,  9, 0,  0, 3},
    '{1, 1, 11,  6, 1,  0, 1,  0, 0,  0, 0,  0, 6},
    '{1, 2, 12, 11, 0, 10, 0,  0, 1, 11, 0,  0, 3},
    '{1, 0, 13,  5, 1,  0, 1,  0, 0,  0, 1,  9, 7},
    '{0, 0,  0,  0, 0,  0, 0,  0, 1, 10, 0,  0, 3},
    '{0, 0,  0,  0, 0,  0, 0,  0, 1, 13, 1, 11, 7},
    '{0, 0,  0,  0, 0,  0, 0,  0, 0,  0, 1, 13, 3},
    '{0, 0,  0,  0, 0,  0, 0,  0, 0,  0, 1, 10, 4},
    '{0, 0,  0,  0, 0,  0, 0,  0, 1, 12, 0,  0, 4},
    '{0, 0,  0,  0, 0,  0, 0,  0, 0,  0, 0,  0, 7},
    '{0, 0,  0,  0, 0,  0, 0,  0, 0,  0, 0,  0, 7},
    '{0, 0,  0,  0, 0,  0, 0,  0, 0,  0, 1, 12, 7}
  };

  task automatic expect1(input string rq, input string what, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then check that cycle's outputs
  task automatic step(input logic dv, input logic [1:0] u, input logic [4:0] d,
                      input logic [4:0] s1, input logic r1, input logic [4:0] s2, input logic r2,
                      input logic xs, input logic xi, input logic [4:0] xd,
                      input logic xc, input logic [4:0] xt, input string rq);
    @(negedge clk);
    disp_valid = dv; disp_unit = u; disp_dst = d; disp_op = d[3:0];
    disp_src1 = s1; disp_rdy1 = r1; disp_src2 = s2; disp_rdy2 = r2;
    #1;
    expect1(rq, "stall", {4'd0, disp_stall}, {4'd0, xs});
    expect1(rq, "iss_valid", {4'd0, iss_valid}, {4'd0, xi});
    if (xi) expect1(rq, "iss_dst", iss_dst, xd);
    expect1(rq, "cdb_valid", {4'd0, cdb_valid}, {4'd0, xc});
    if (xc) expect1(rq, "cdb_tag", cdb_tag, xt);
  endtask

  task automatic idle(input logic xi, input logic [4:0] xd, input logic xc,
                      input logic [4:0] xt, input string rq);
    step(0, 0, 0, 0, 0, 0, 0, 0, xi, xd, xc, xt, rq);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2: empty pool after reset
    idle(0, 0, 0, 0, "R2");
    idle(0, 0, 0, 0, "R2");

    foreach (TBL[k]) begin
      step(TBL[k].dv, TBL[k].u, TBL[k].d, TBL[k].s1, TBL[k].r1, TBL[k].s2, TBL[k].r2,
           TBL[k].xs, TBL[k].xi, TBL[k].xd, TBL[k].xc, TBL[k].xt,
           $sformatf("R%0d", TBL[k].rq));
    end
    idle(0, 0, 0, 0, "R2");

    // R1: both load/store stations wait, third is refused
    step(1, 1, 30, 20, 0, 0, 1, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 31, 21, 0, 0, 1, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 32,  0, 1, 0, 1, 1, 0, 0, 0, 0, "R1");
    // R6: integer station stalls in its issue cycle, refills next
    step(1, 0, 20,  0, 1, 0, 1, 0, 0, 0, 0, 0, "R6");
    step(1, 0, 21,  0, 1, 0, 1, 1, 1, 20, 0, 0, "R6");
    step(1, 0, 21,  0, 1, 0, 1, 0, 0, 0, 1, 20, "R6");
    // R5: woken load 30 is older than integer op 21
    idle(1, 30, 0, 0, "R5");
    idle(1, 21, 0, 0, "R7");
    // R4: FP dispatched while its source tag 21 is on the bus
    step(1, 2, 40, 21, 0, 0, 1, 0, 0, 0, 1, 21, "R4");
    idle(1, 31, 1, 30, "R5");
    idle(1, 40, 0, 0, "R4");
    idle(0, 0, 0, 0, "R7");
    idle(0, 0, 1, 31, "R7");
    idle(0, 0, 1, 40, "R7");
    idle(0, 0, 0, 0, "R2");

    // R9: back-to-back long issues; R8: integer op waits for a free bus slot
    step(1, 2, 50, 0, 1, 0, 1, 0, 0, 0, 0, 0, "R9");
    step(1, 2, 51, 0, 1, 0, 1, 0, 1, 50, 0, 0, "R9");
    step(1, 0, 52, 0, 1, 0, 1, 0, 1, 51, 0, 0, "R9");
    idle(0, 0, 0, 0, "R8");
    idle(0, 0, 1, 50, "R8");
    idle(1, 52, 1, 51, "R8");
    idle(0, 0, 1, 52, "R7");
    idle(0, 0, 0, 0, "R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule